// File: doc/BRIEF.md
# Programmable SMBus Master Serial-Clock Generator

This block produces the serial clock for a two-wire SMBus or I2C master. An 8-bit rate value N sets the clock period. At the start of every half-period an 8-bit up-counting timer is preset to N. The SCL level toggles when that timer wraps past its all-ones value. The low half therefore lasts 256 − N system clocks. The released (high) half lasts 258 − N clocks, because the count starts only after a two-stage synchronizer reports the line high. The two extra cycles give the wire time to rise. They also let a slave that holds the line low stretch the clock.

The SCL output is open-drain style. A single pull-low request is high to pull the wire low and low to leave it high-impedance. The same rate value also scales a bus-free detector. The detector watches the synchronized SCL and SDA lines and raises a one-cycle flag once both have stayed high for about ten low-periods. A controller uses this flag to learn that it may start a transfer. Byte shifting, START/STOP generation, arbitration and addressing are handled elsewhere.

Top module: `scl_rate_gen`

## Requirements
- R1: The rate register is 8 bits, resets to 0x00, is loaded from `rate_wdata` on any clock edge with `rate_we` high, and is always visible on `rate_rdata`; after reset `scl_drive_low` and `bus_free` are 0.
- R2: A rate write does not change the half-period already running; the new value first sets the length of the next half-period.
- R3: While enabled, each pull-low phase (`scl_drive_low` = 1) lasts exactly 256 − N clock cycles, for N from 0x00 to 0xFF.
- R4: While enabled and with no slave holding SCL low, each released phase (`scl_drive_low` = 0) lasts exactly 258 − N cycles: two cycles of synchronizer latency followed by a count of 256 − N.
- R5: If a slave keeps SCL low for S cycles after the block releases it, the released phase lasts 258 − N + S cycles, so the high time seen on the wire is still 258 − N.
- R6: With `enable` low, `scl_drive_low` is 0 one edge after `enable` falls and stays 0 regardless of rate writes, and the timer holds N; when `enable` rises, a pull-low phase starts on the next edge.
- R7: Once both SCL and SDA are high, `bus_free` rises on the (10·(256 − N) + 16 + 2)-th clock edge; the +2 is the synchronizer latency.
- R8: `bus_free` is high for exactly one cycle and does not repeat while both lines stay high; a low level on either line restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_we | input | 1 | Write strobe for the rate register |
| rate_wdata | input | 8 | Rate value N to be written |
| rate_rdata | output | 8 | Current rate register contents |
| enable | input | 1 | Master clock generation on |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it (high-Z) |
| scl_in | input | 1 | SCL level seen on the wire |
| sda_in | input | 1 | SDA level seen on the wire |
| bus_free | output | 1 | One-cycle pulse: both lines idle for the timeout |

## Verification
Phase widths are measured for N = 0x00, 0x80 and 0xFF. These three values hit the longest half-period, a mid-range half-period, and the shortest case, where a one-cycle low phase has to be told apart from stale synchronizer data. A stretched first high phase at N = 0x80 shows that the released-phase count waits for the wire and not for the block's own release. A rate write in the middle of a low phase tells reload-at-boundary apart from immediate effect. Bus-free timing is measured for several N, and again with an SCL glitch in the middle of the count, to separate restart from continuation.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    localparam int RATE_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int BF_MULT     = 10;
    localparam int BF_OFFSET   = 16;
    localparam int BF_W        = $clog2(BF_MULT * (2 ** RATE_W) + BF_OFFSET + 1);
    localparam int SETTLE_W    = $clog2(SYNC_STAGES + 1);

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [BF_W-1:0]   bf_cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic load;
        logic count_en;
    } tmr_ctl_t;

    // Idle-bus timeout length in clocks for a given rate value.
    function automatic bf_cnt_t bf_limit(rate_t n);
        bf_cnt_t span;
        span = bf_cnt_t'((2 ** RATE_W) - int'(n));
        return bf_cnt_t'(BF_MULT) * span + bf_cnt_t'(BF_OFFSET);
    endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= d;
            end
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/scl_half_timer.sv
module scl_half_timer
    import scl_rate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_ctl_t ctl,
    input  rate_t    preset,
    output rate_t    value,
    output logic     at_max
);

    always_ff @(posedge clk) begin
        if (rst)               value <= '0;
        else if (ctl.load)     value <= preset;
        else if (ctl.count_en) value <= value + rate_t'(1);
    end

    assign at_max = (value == '1);

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_rate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     scl_hi,
    input  logic     at_max,
    output phase_e   phase,
    output tmr_ctl_t ctl
);

    localparam logic [SETTLE_W-1:0] SETTLE_LOAD = SETTLE_W'(SYNC_STAGES);

    phase_e               phase_nxt;
    logic [SETTLE_W-1:0]  settle;
    logic                 line_ready;

    // The synchronizer output only reflects the released wire once its
    // pipeline has refilled after the release edge.
    assign line_ready = (settle == '0) && scl_hi;

    always_comb begin
        phase_nxt    = phase;
        ctl          = '0;
        unique case (phase)
            PH_IDLE: begin
                ctl.load = 1'b1;
                if (enable) phase_nxt = PH_LOW;
            end
            PH_LOW: begin
                if (!enable) begin
                    ctl.load  = 1'b1;
                    phase_nxt = PH_IDLE;
                end else if (at_max) begin
                    ctl.load  = 1'b1;
                    phase_nxt = PH_HIGH;
                end else begin
                    ctl.count_en = 1'b1;
                end
            end
            PH_HIGH: begin
                if (!enable) begin
                    ctl.load  = 1'b1;
                    phase_nxt = PH_IDLE;
                end else if (line_ready) begin
                    if (at_max) begin
                        ctl.load  = 1'b1;
                        phase_nxt = PH_LOW;
                    end else begin
                        ctl.count_en = 1'b1;
                    end
                end
            end
            default: begin
                ctl.load  = 1'b1;
                phase_nxt = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            settle <= '0;
        end else begin
            phase <= phase_nxt;
            if (phase != PH_HIGH && phase_nxt == PH_HIGH) settle <= SETTLE_LOAD;
            else if (settle != '0)                      settle <= settle - 1'b1;
        end
    end

endmodule

// File: rtl/scl_bus_free.sv
module scl_bus_free
    import scl_rate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_hi,
    input  logic  sda_hi,
    input  rate_t rate,
    output logic  pulse
);

    bf_cnt_t idle_cnt;
    bf_cnt_t limit;
    logic    expired;

    assign limit = bf_limit(rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            expired  <= 1'b0;
            pulse    <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (!(scl_hi && sda_hi)) begin
                idle_cnt <= '0;
                expired  <= 1'b0;
            end else if (!expired) begin
                if (idle_cnt == limit - 1'b1) begin
                    pulse   <= 1'b1;
                    expired <= 1'b1;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    output logic [RATE_W-1:0] rate_rdata,
    input  logic              enable,
    output logic              scl_drive_low,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              bus_free
);

    rate_t    rate_q;
    logic [1:0] line_sync;
    logic     scl_hi;
    logic     sda_hi;
    phase_e   phase;
    tmr_ctl_t tctl;
    rate_t    tmr_value;
    logic     at_max;

    always_ff @(posedge clk) begin
        if (rst)          rate_q <= '0;
        else if (rate_we) rate_q <= rate_wdata;
    end
    assign rate_rdata = rate_q;

    scl_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b00)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (line_sync)
    );
    assign scl_hi = line_sync[1];
    assign sda_hi = line_sync[0];

    scl_half_timer u_tmr (
        .clk    (clk),
        .rst    (rst),
        .ctl    (tctl),
        .preset (rate_q),
        .value  (tmr_value),
        .at_max (at_max)
    );

    scl_phase_ctrl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .scl_hi (scl_hi),
        .at_max (at_max),
        .phase  (phase),
        .ctl    (tctl)
    );

    scl_bus_free u_bf (
        .clk    (clk),
        .rst    (rst),
        .scl_hi (scl_hi),
        .sda_hi (sda_hi),
        .rate   (rate_q),
        .pulse  (bus_free)
    );

    assign scl_drive_low = (phase == PH_LOW);

endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk
    import scl_rate_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   rate_we,
    input logic   enable,
    input logic   drive_low,
    input logic   bus_free,
    input phase_e phase,
    input rate_t  tmr,
    input rate_t  rate,
    input logic   scl_hi,
    input logic   sda_hi
);

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rate_we |=> $stable(rate)); // R1

    AST_LOW_ENDS_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($fell(drive_low) && $past(enable)) |-> ($past(tmr) == '1)); // R3

    AST_LOW_STARTS_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(drive_low) && $past(phase) == PH_HIGH) |-> ($past(tmr) == '1)); // R4

    AST_HIGH_WAITS_LINE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH && enable && !scl_hi) |=> (tmr == $past(tmr))); // R5

    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !drive_low); // R6

    AST_IDLE_HOLDS_RATE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> (tmr == $past(rate))); // R6

    AST_BF_LINES_IDLE: assert property (@(posedge clk) disable iff (rst)
        bus_free |-> $past(scl_hi && sda_hi)); // R7

    AST_BF_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bus_free |=> !bus_free); // R8

endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rate_we   (rate_we),
    .enable    (enable),
    .drive_low (scl_drive_low),
    .bus_free  (bus_free),
    .phase     (phase),
    .tmr       (tmr_value),
    .rate      (rate_q),
    .scl_hi    (scl_hi),
    .sda_hi    (sda_hi)
);

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rate_we = 1'b0;
    logic [7:0] rate_wdata = 8'h00;
    logic [7:0] rate_rdata;
    logic       enable = 1'b0;
    logic       scl_drive_low;
    logic       bus_free;
    logic       stretch_hold = 1'b0;
    logic       scl_pull = 1'b0;
    logic       sda_pull = 1'b0;
    logic       scl_line;
    logic       sda_line;

    int n_vec = 0;
    int n_bad = 0;
    int stretch_pend = 0;
    int hold_cnt = 0;
    bit finished = 1'b0;

    typedef struct {
        bit    lvl;
        int    width;
        string req;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    assign scl_line = !(scl_drive_low || stretch_hold || scl_pull);
    assign sda_line = !sda_pull;

    scl_rate_gen dut (
        .clk           (clk),
        .rst           (rst),
        .rate_we       (rate_we),
        .rate_wdata    (rate_wdata),
        .rate_rdata    (rate_rdata),
        .enable        (enable),
        .scl_drive_low (scl_drive_low),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .bus_free      (bus_free)
    );

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: measures each completed phase and compares against the queue.
    bit mon_started = 1'b0;
    bit mon_prev = 1'b0;
    int mon_run = 0;
    always @(negedge clk) begin
        if (!enable) begin
            mon_started = 1'b0;
            mon_prev    = 1'b0;
            mon_run     = 0;
        end else if (scl_drive_low != mon_prev) begin
            if (mon_started && exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk(it.lvl == mon_prev && it.width == mon_run, it.req,
                    it.lvl ? "pull-low width" : "released width",
                    mon_run, it.width);
            end
            mon_started = 1'b1;
            mon_run     = 1;
            mon_prev    = scl_drive_low;
        end else begin
            mon_run++;
        end
    end

    // Slave model: holds SCL low for a number of cycles after a release.
    bit st_prev = 1'b0;
    always @(negedge clk) begin
        if (stretch_hold) begin
            hold_cnt--;
            if (hold_cnt == 0) stretch_hold = 1'b0;
        end else if (st_prev && !scl_drive_low && stretch_pend > 0) begin
            stretch_hold = 1'b1;
            hold_cnt     = stretch_pend;
            stretch_pend = 0;
        end
        st_prev = scl_drive_low;
    end

    task automatic write_rate(logic [7:0] v);
        @(negedge clk);
        rate_we    = 1'b1;
        rate_wdata = v;
        @(negedge clk);
        rate_we    = 1'b0;
    endtask

    task automatic push(bit lvl, int width, string req);
        item_t it;
        it.lvl   = lvl;
        it.width = width;
        it.req   = req;
        exp_q.push_back(it);
    endtask

    task automatic drain_and_stop();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_q.size() == 0, "R3", "phases left unobserved", exp_q.size(), 0);
        exp_q.delete();
        enable = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Driver: expected widths from the requirements, low 256-N, high 258-N(+S).
    task automatic run_rate(int n, int phases, int stretch);
        write_rate(8'(n));
        for (int i = 0; i < phases; i++) begin
            push(1'b1, 256 - n, "R3");
            push(1'b0, 258 - n + ((i == 0) ? stretch : 0), (i == 0 && stretch > 0) ? "R5" : "R4");
        end
        stretch_pend = stretch;
        @(negedge clk);
        enable = 1'b1;
        drain_and_stop();
    endtask

    task automatic bf_measure(int n, string req);
        int k = 0;
        write_rate(8'(n));
        sda_pull = 1'b1;
        repeat (4) @(negedge clk);
        sda_pull = 1'b0;
        while (k < 6000) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (bus_free) break;
        end
        chk(k == 10 * (256 - n) + 16 + 2, req, "edges to bus-free", k, 10 * (256 - n) + 16 + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rate_rdata == 8'h00, "R1", "rate after reset", rate_rdata, 0);
        chk(scl_drive_low == 1'b0, "R1", "scl pull after reset", scl_drive_low, 0);
        chk(bus_free == 1'b0, "R1", "bus_free after reset", bus_free, 0);
        write_rate(8'h5A);
        chk(rate_rdata == 8'h5A, "R1", "rate readback", rate_rdata, 8'h5A);

        // R3/R4 at the longest and shortest half-periods, R5 with a stretch
        run_rate(8'h00, 1, 0);
        run_rate(8'h80, 2, 7);
        run_rate(8'hFF, 3, 0);

        // R2: write mid low phase; first low keeps old N, later phases use new N
        write_rate(8'hF0);
        push(1'b1, 16, "R2");
        push(1'b0, 10, "R2");
        push(1'b1, 8, "R2");
        push(1'b0, 10, "R2");
        @(negedge clk);
        enable = 1'b1;
        repeat (5) @(negedge clk);
        rate_we    = 1'b1;
        rate_wdata = 8'hF8;
        @(negedge clk);
        rate_we    = 1'b0;
        drain_and_stop();

        // R6: disable mid pull-low, writes while disabled, re-enable
        write_rate(8'h80);
        @(negedge clk);
        enable = 1'b1;
        repeat (40) @(negedge clk);
        chk(scl_drive_low == 1'b1, "R6", "pulling before disable", scl_drive_low, 1);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R6", "release one edge after disable", scl_drive_low, 0);
        begin
            int seen = 0;
            write_rate(8'hFE);
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (scl_drive_low) seen++;
            end
            chk(seen == 0, "R6", "pull cycles while disabled", seen, 0);
        end
        enable = 1'b1;
        @(negedge clk);
        chk(scl_drive_low == 1'b1, "R6", "pull-low one edge after enable", scl_drive_low, 1);
        enable = 1'b0;
        repeat (4) @(negedge clk);

        // R7: bus-free timeout for several N
        bf_measure(8'hFF, "R7");
        bf_measure(8'hF0, "R7");
        bf_measure(8'h00, "R7");

        // R8: one cycle, no repeat while idle
        @(negedge clk);
        chk(bus_free == 1'b0, "R8", "bus_free second cycle", bus_free, 0);
        begin
            int extra = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (bus_free) extra++;
            end
            chk(extra == 0, "R8", "repeat pulses while idle", extra, 0);
        end

        // R8: SCL glitch mid-count restarts the timeout
        write_rate(8'hFF);
        sda_pull = 1'b1;
        repeat (4) @(negedge clk);
        sda_pull = 1'b0;
        begin
            int early = 0;
            int k = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (bus_free) early++;
            end
            chk(early == 0, "R8", "pulse before glitch", early, 0);
            scl_pull = 1'b1;
            repeat (4) @(negedge clk);
            scl_pull = 1'b0;
            while (k < 6000) begin
                @(posedge clk);
                k++;
                @(negedge clk);
                if (bus_free) break;
            end
            chk(k == 28, "R8", "edges to bus-free after restart", k, 28);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule